// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the combinational execute stage of a small 16-bit microcontroller core. It takes a source operand, a destination operand, an operation code, a byte/word select and the current carry, zero, negative and overflow flags. In the same cycle it returns the result, the new flag set and a write-enable that tells the register write-back stage whether the result should be stored. Operand fetch, addressing, the register file and stack handling belong to the surrounding core.

Twelve two-operand operations are covered: binary add and subtract with and without carry, compare, packed-BCD add, the bitwise set, clear, test, AND and XOR, and move. Four one-operand operations act on the destination input: arithmetic right shift, rotate right through carry, byte swap and sign extension. In byte mode only the low eight bits of each operand take part and the flags are taken from the 8-bit result. The block has no clock and no internal state, and the result settles combinationally. It therefore has no flow-control handshake: the core holds the inputs stable for as long as it needs the outputs.

Top module: `alu16_core`

## Requirements
- R1: `op_i` codes are 0 move, 1 add, 2 add-with-carry, 3 subtract-with-carry, 4 subtract, 5 compare, 6 decimal add, 7 bit-test, 8 bit-clear, 9 bit-set, 10 XOR, 11 AND, 12 rotate-right-through-carry, 13 byte swap, 14 arithmetic right shift, 15 sign extend. `wr_o` is 0 for compare and bit-test and 1 for every other code.
- R2: With `byte_i`=1, every operation except byte swap and sign extend uses only bits 7:0 of each operand. Result bits 15:8 are 0, and N, Z, C and V are taken at the 8-bit boundary (N from bit 7).
- R3: Add gives dst+src and add-with-carry gives dst+src+C. C is the carry out of the active width. V is 1 when both operands have the same sign and the result sign differs. N is the result MSB and Z is 1 for a zero result.
- R4: Subtract and compare give dst+NOT src+1, and subtract-with-carry gives dst+NOT src+C. C is 1 when no borrow occurs. V is 1 when the operands differ in sign and the result sign equals the source sign. N and Z follow the result. Compare yields the same result and flags as subtract.
- R5: Decimal add treats each nibble as a BCD digit and gives src+dst+C. C is 1 when the true sum exceeds 99 (byte) or 9999 (word), and the result is the sum modulo 100 or 10000. N is the result MSB, Z is 1 for a zero result, and V is passed through unchanged.
- R6: AND and bit-test give src AND dst. XOR gives src XOR dst. For all three, C is 1 when the result is nonzero, N is the result MSB and Z is 1 for a zero result. V is 0 for AND and bit-test. For XOR, V is 1 exactly when both operands are negative.
- R7: Move gives src, bit-clear gives NOT src AND dst and bit-set gives src OR dst. All four flags pass through unchanged.
- R8: Arithmetic right shift moves dst right by one and keeps its MSB. Rotate-right-through-carry moves dst right by one and loads the incoming C into the MSB. For both, C takes the old bit 0, V is 0, and N and Z follow the result.
- R9: Byte swap exchanges bits 15:8 and 7:0 of dst in either mode and leaves all four flags unchanged.
- R10: Sign extend copies dst bit 7 into bits 15:8 in either mode. N and Z follow the 16-bit result, C is 1 when the result is nonzero and V is 0.
- R11: `flags_i` and `flags_o` hold C in bit 0, Z in bit 1, N in bit 2 and V in bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; sole operand of the one-operand codes |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width, 0 word width |
| flags_i | input | 4 | Incoming flags {V,N,Z,C} |
| res_o | output | 16 | Result |
| flags_o | output | 4 | Updated flags {V,N,Z,C} |
| wr_o | output | 1 | Result should be written back |

## Verification
The block holds no state, so an internal fault shows at the ports in the same evaluation as the input that exposes it. A wrongly chosen sign position would show as bad N or V only when bits 7 and 15 differ. A decimal-correction fault would show only on digit sums above nine. A flag routing error would show as a pass-through flag moving when it should hold. The sweeps therefore use byte operands whose upper bits are garbage, digit pairs that span every carry case, and both values of the incoming carry. A result or flag that is wrong for even one such input pattern appears on `res_o` or `flags_o` straight away.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_SUB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_DADD = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_AND  = 4'd11,
    OP_RRC  = 4'd12,
    OP_SWAP = 4'd13,
    OP_RRA  = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  // flag vector bit positions (R11)
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_W = 4;

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          byte_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  localparam int HALF = DW / 2;
  localparam int SBW  = $clog2(DW);

  logic [DW:0]     full;
  logic [DW-1:0]   mask;
  logic [SBW-1:0]  sb;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
  assign mask   = byte_i ? {{(DW-HALF){1'b0}}, {HALF{1'b1}}} : {DW{1'b1}};
  assign sum_o  = full[DW-1:0] & mask;
  assign cout_o = byte_i ? full[HALF] : full[DW];
  assign sb     = byte_i ? SBW'(HALF-1) : SBW'(DW-1);
  assign ovf_o  = (a_i[sb] == b_i[sb]) && (sum_o[sb] != a_i[sb]);

endmodule

// File: rtl/alu16_bcd.sv
module alu16_bcd #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          byte_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);
  localparam int NDIG = DW / 4;
  localparam int HDIG = NDIG / 2;

  logic [NDIG:0]   dc;
  logic [DW-1:0]   raw;

  assign dc[0] = cin_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [4:0] t;
    logic       over;
    assign t    = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, dc[g]};
    assign over = (t > 5'd9);
    assign raw[4*g +: 4] = over ? (t[3:0] + 4'd6) : t[3:0];
    assign dc[g+1] = over;
  end

  assign sum_o  = byte_i ? {{(DW-4*HDIG){1'b0}}, raw[4*HDIG-1:0]} : raw;
  assign cout_o = byte_i ? dc[HDIG] : dc[NDIG];

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] d_raw_i,
  input  logic [DW-1:0] mask_i,
  input  logic          cin_i,
  input  logic          byte_i,
  output logic [DW-1:0] res_o
);
  localparam int HALF = DW / 2;
  localparam int SBW  = $clog2(DW);

  logic [SBW-1:0] sb;
  assign sb = byte_i ? SBW'(HALF-1) : SBW'(DW-1);

  always_comb begin
    res_o = s_i;
    unique case (op_i)
      OP_AND, OP_BIT: res_o = s_i & d_i;
      OP_BIC:         res_o = ~s_i & d_i & mask_i;
      OP_BIS:         res_o = s_i | d_i;
      OP_XOR:         res_o = s_i ^ d_i;
      OP_RRA: begin
        res_o     = d_i >> 1;
        res_o[sb] = d_i[sb];
      end
      OP_RRC: begin
        res_o     = d_i >> 1;
        res_o[sb] = cin_i;
      end
      OP_SWAP:        res_o = {d_raw_i[HALF-1:0], d_raw_i[DW-1:HALF]};
      OP_SXT:         res_o = {{(DW-HALF){d_raw_i[HALF-1]}}, d_raw_i[HALF-1:0]};
      default:        res_o = s_i;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   src_i,
  input  logic [DW-1:0]   dst_i,
  input  logic [3:0]      op_i,
  input  logic            byte_i,
  input  logic [FL_W-1:0] flags_i,
  output logic [DW-1:0]   res_o,
  output logic [FL_W-1:0] flags_o,
  output logic            wr_o
);
  localparam int HALF = DW / 2;
  localparam int SBW  = $clog2(DW);

  alu_op_e        op;
  logic           full_width;
  logic           narrow;
  logic [DW-1:0]  mask;
  logic [DW-1:0]  s_m, d_m, add_b;
  logic           is_sub, add_cin;
  logic [DW-1:0]  add_sum, bcd_sum, bit_res;
  logic           add_cout, add_ovf, bcd_cout;
  logic [SBW-1:0] sb;
  logic           r_neg, r_zero;

  assign op         = alu_op_e'(op_i);
  assign full_width = (op == OP_SWAP) || (op == OP_SXT);
  assign narrow     = byte_i && !full_width;
  assign mask       = byte_i ? {{(DW-HALF){1'b0}}, {HALF{1'b1}}} : {DW{1'b1}};
  assign s_m        = src_i & mask;
  assign d_m        = dst_i & mask;
  assign is_sub     = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign add_b      = is_sub ? (~src_i & mask) : s_m;

  always_comb begin
    unique case (op)
      OP_ADD:         add_cin = 1'b0;
      OP_SUB, OP_CMP: add_cin = 1'b1;
      default:        add_cin = flags_i[FL_C];
    endcase
  end

  alu16_adder #(.DW(DW)) u_add (
    .a_i(d_m), .b_i(add_b), .cin_i(add_cin), .byte_i(byte_i),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  alu16_bcd #(.DW(DW)) u_bcd (
    .a_i(d_m), .b_i(s_m), .cin_i(flags_i[FL_C]), .byte_i(byte_i),
    .sum_o(bcd_sum), .cout_o(bcd_cout)
  );

  alu16_bitops #(.DW(DW)) u_bit (
    .op_i(op), .s_i(s_m), .d_i(d_m), .d_raw_i(dst_i), .mask_i(mask),
    .cin_i(flags_i[FL_C]), .byte_i(byte_i), .res_o(bit_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: res_o = add_sum;
      OP_DADD:                                  res_o = bcd_sum;
      default:                                  res_o = bit_res;
    endcase
  end

  assign sb     = narrow ? SBW'(HALF-1) : SBW'(DW-1);
  assign r_neg  = res_o[sb];
  assign r_zero = (res_o == '0);
  assign wr_o   = !((op == OP_CMP) || (op == OP_BIT));

  always_comb begin
    flags_o = flags_i;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        flags_o[FL_C] = add_cout;
        flags_o[FL_V] = add_ovf;
        flags_o[FL_N] = r_neg;
        flags_o[FL_Z] = r_zero;
      end
      OP_DADD: begin
        flags_o[FL_C] = bcd_cout;
        flags_o[FL_N] = r_neg;
        flags_o[FL_Z] = r_zero;
      end
      OP_AND, OP_BIT, OP_XOR: begin
        flags_o[FL_C] = !r_zero;
        flags_o[FL_V] = (op == OP_XOR) ? (s_m[sb] & d_m[sb]) : 1'b0;
        flags_o[FL_N] = r_neg;
        flags_o[FL_Z] = r_zero;
      end
      OP_RRA, OP_RRC: begin
        flags_o[FL_C] = d_m[0];
        flags_o[FL_V] = 1'b0;
        flags_o[FL_N] = r_neg;
        flags_o[FL_Z] = r_zero;
      end
      OP_SXT: begin
        flags_o[FL_C] = !r_zero;
        flags_o[FL_V] = 1'b0;
        flags_o[FL_N] = r_neg;
        flags_o[FL_Z] = r_zero;
      end
      default: flags_o = flags_i;
    endcase
  end

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input logic [DW-1:0]   src_i,
  input logic [DW-1:0]   dst_i,
  input logic [3:0]      op_i,
  input logic            byte_i,
  input logic [FL_W-1:0] flags_i,
  input logic [DW-1:0]   res_o,
  input logic [FL_W-1:0] flags_o,
  input logic            wr_o
);
  localparam int HALF = DW / 2;

  always_comb begin
    AST_WRITE_GATE: assert (wr_o == !(op_i == OP_CMP || op_i == OP_BIT)); // R1
    if (byte_i && op_i != OP_SWAP && op_i != OP_SXT)
      AST_BYTE_HIGH_CLEAR: assert (res_o[DW-1:HALF] == '0); // R2
    if (op_i == OP_MOV || op_i == OP_BIC || op_i == OP_BIS)
      AST_FLAGS_KEPT: assert (flags_o == flags_i); // R7
    if (op_i == OP_SWAP)
      AST_SWAP_FLAGS_KEPT: assert (flags_o == flags_i); // R9
    if (op_i == OP_SXT)
      AST_SXT_UPPER_COPY: assert (res_o[DW-1:HALF] == {(DW-HALF){dst_i[HALF-1]}} && !flags_o[FL_V]); // R10
    if (op_i == OP_SUB && !byte_i)
      AST_SUB_OVERFLOW: assert (flags_o[FL_V] ==
        ((src_i[DW-1] != dst_i[DW-1]) && (res_o[DW-1] == src_i[DW-1]))); // R4
    if (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR)
      AST_LOGIC_CARRY: assert (flags_o[FL_C] == (res_o != '0)); // R6
    if (op_i == OP_RRA || op_i == OP_RRC)
      AST_SHIFT_CARRY: assert (flags_o[FL_C] == dst_i[0] && !flags_o[FL_V]); // R8
  end

endmodule

bind alu16_core alu16_core_chk #(.DW(DW)) u_chk (
  .src_i(src_i), .dst_i(dst_i), .op_i(op_i), .byte_i(byte_i),
  .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o), .wr_o(wr_o)
);

// File: tb/tb_alu16_core.sv
module tb_alu16_core;

  logic        clk = 1'b0;
  logic [15:0] src, dst, res;
  logic [3:0]  op, fin, fout;
  logic        bw, wr;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu16_core dut (
    .src_i(src), .dst_i(dst), .op_i(op), .byte_i(bw),
    .flags_i(fin), .res_o(res), .flags_o(fout), .wr_o(wr)
  );

  function automatic string reqtag(int o);
    case (o)
      1, 2:           return "R3";
      3, 4, 5:        return "R4";
      6:              return "R5";
      7, 10, 11:      return "R6";
      0, 8, 9:        return "R7";
      12, 14:         return "R8";
      13:             return "R9";
      default:        return "R10";
    endcase
  endfunction

  function automatic int dec_of(int x);
    return (x & 15) + 10 * ((x >> 4) & 15) + 100 * ((x >> 8) & 15) + 1000 * ((x >> 12) & 15);
  endfunction

  function automatic int bcd_of(int x);
    return (x % 10) | (((x / 10) % 10) << 4) | (((x / 100) % 10) << 8) | (((x / 1000) % 10) << 12);
  endfunction

  // flags packed {V,N,Z,C} per R11
  task automatic model(input int o, input int s_in, input int d_in, input bit b,
                       input int f, output int r, output int fl, output int w);
    int wd, m, s, d, sb, t, c, v, n, z, lim;
    wd = b ? 8 : 16;
    m  = (1 << wd) - 1;
    s  = s_in & m;
    d  = d_in & m;
    sb = wd - 1;
    c  = f & 1; z = (f >> 1) & 1; n = (f >> 2) & 1; v = (f >> 3) & 1;
    r  = 0;
    w  = (o == 5 || o == 7) ? 0 : 1;
    case (o)
      1, 2: begin
        t = d + s + ((o == 2) ? (f & 1) : 0);
        r = t & m; c = (t >> wd) & 1;
        v = (((s >> sb) & 1) == ((d >> sb) & 1) && ((r >> sb) & 1) != ((s >> sb) & 1)) ? 1 : 0;
      end
      3, 4, 5: begin
        t = d + ((~s) & m) + ((o == 3) ? (f & 1) : 1);
        r = t & m; c = (t >> wd) & 1;
        v = (((s >> sb) & 1) != ((d >> sb) & 1) && ((r >> sb) & 1) == ((s >> sb) & 1)) ? 1 : 0;
      end
      6: begin
        lim = b ? 100 : 10000;
        t = dec_of(s) + dec_of(d) + (f & 1);
        c = (t >= lim) ? 1 : 0;
        r = bcd_of(t % lim);
      end
      7, 11: begin r = s & d; c = (r != 0) ? 1 : 0; v = 0; end
      10: begin
        r = s ^ d; c = (r != 0) ? 1 : 0;
        v = (((s >> sb) & 1) == 1 && ((d >> sb) & 1) == 1) ? 1 : 0;
      end
      0: r = s;
      8: r = (~s) & d & m;
      9: r = s | d;
      14: begin r = (d >> 1) | (d & (1 << sb)); c = d & 1; v = 0; end
      12: begin r = (d >> 1) | ((f & 1) << sb); c = d & 1; v = 0; end
      13: r = ((d_in & 255) << 8) | ((d_in >> 8) & 255);
      default: begin
        r = ((d_in & 128) != 0) ? ((d_in & 255) | 16'hFF00) : (d_in & 255);
        c = (r != 0) ? 1 : 0; v = 0; sb = 15;
      end
    endcase
    if (!(o == 0 || o == 8 || o == 9 || o == 13)) begin
      n = (r >> sb) & 1;
      z = (r == 0) ? 1 : 0;
    end
    fl = c | (z << 1) | (n << 2) | (v << 3);
  endtask

  task automatic apply(input int o, input int s_in, input int d_in, input bit b, input int f);
    int er, ef, ew;
    string tg;
    @(posedge clk);
    #1;
    op = 4'(o); src = 16'(s_in); dst = 16'(d_in); bw = b; fin = 4'(f);
    #3;
    model(o, s_in, d_in, b, f, er, ef, ew);
    tg = (b && o != 13 && o != 15) ? "R2" : reqtag(o);
    total++;
    if (res !== 16'(er)) begin
      bad++;
      $display("FAIL %s result op=%0d s=%h d=%h b=%0d cin=%0d: actual=%h expected=%h",
               tg, o, s_in[15:0], d_in[15:0], b, f & 1, res, 16'(er));
    end
    total++;
    if (fout !== 4'(ef)) begin
      bad++;
      $display("FAIL %s flags op=%0d s=%h d=%h b=%0d fin=%h: actual=%h expected=%h",
               tg, o, s_in[15:0], d_in[15:0], b, f, fout, 4'(ef));
    end
    total++;
    if (wr !== ew[0]) begin
      bad++;
      $display("FAIL R1 write-enable op=%0d: actual=%0d expected=%0d", o, wr, ew[0]);
    end
  endtask

  initial begin
    int s, d;
    op = '0; src = '0; dst = '0; bw = 1'b0; fin = '0;
    // idle vector: move of zero keeps flags, writes zero (R7)
    apply(0, 0, 0, 1'b0, 0);
    // directed corners: byte and word carry/overflow boundaries (R3, R4, R5)
    apply(1, 16'h0001, 16'h7FFF, 1'b0, 0);
    apply(1, 16'h0001, 16'h00FF, 1'b1, 0);
    apply(4, 16'h0001, 16'h0000, 1'b0, 0);
    apply(5, 16'h0005, 16'h0005, 1'b1, 0);
    apply(6, 16'h0001, 16'h9999, 1'b0, 0);
    apply(6, 16'h0000, 16'h0099, 1'b1, 1);
    // byte-mode sweep, garbage in upper bits, both carries
    for (int o = 0; o < 16; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 256; a += 9)
          for (int bb = 0; bb < 256; bb += 7) begin
            s = (o == 6) ? bcd_of(a % 100) : a;
            d = (o == 6) ? bcd_of(bb % 100) : bb;
            s = s | (((a * 37) & 255) << 8);
            d = d | (((bb * 91) & 255) << 8);
            apply(o, s, d, 1'b1, ci | ((a & 3) << 1) | ((bb & 1) << 3));
          end
    // word-mode random sweep
    for (int o = 0; o < 16; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int k = 0; k < 400; k++) begin
          s = int'($urandom() & 32'hFFFF);
          d = int'($urandom() & 32'hFFFF);
          if (o == 6) begin
            s = bcd_of(s % 10000);
            d = bcd_of(d % 10000);
          end
          if (k == 0) begin s = 0; d = 0; end
          apply(o, s, d, 1'b0, ci | (k & 14));
        end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule